// File: doc/BRIEF.md
# High-Speed Reset Chirp Handshake Controller

This block runs the host side of the speed-detection exchange that takes place while a downstream port is held in bus reset. A start command makes the host drive SE0 for a programmed reset time. While driving SE0, the block watches the decoded receive line for a device chirp K. A chirp K that stays steady long enough is taken as a request for high speed. The host waits for that chirp to end and then answers with its own train of chirps, alternating K and J. It stops the train a safe margin before reset ends. Finally it reports the port as high-speed. If no qualified device chirp arrives in time, the host drives no chirps and the port remains full-speed.

All time windows come from a reference clock frequency parameter (`CLK_KHZ`) and are converted to cycle counts: the reset length (`RESET_US`, 10 ms by default), the qualification time (`FILT_NS`, 2.5 µs), the width of each host chirp (`CHIRP_US`, 50 µs) and the cutoff margin (`CUTOFF_US`, 300 µs). The derived counts used below are `RESET_CYC`, `FILT_CYC`, `CHIRP_CYC` and `CUT_CYC`, where `CUT_CYC = RESET_CYC - CUTOFF_US*CLK_KHZ/1000`. Cycle t means the t-th cycle after the edge that samples `start`, counting from 0. A start command that arrives mid-handshake abandons the current run and restarts it.

Top module: `hs_rst_handshake`

## Requirements
- R1: After `rst_n` is released, with no start command, all drive outputs, `rst_done` and `hs_mode` are low.
- R2: A start command sampled high makes `drv_se0` high from cycle 0. Reset signalling (SE0 or chirps) covers cycles 0 to `RESET_CYC-1`. `rst_done` is high for exactly one cycle, at cycle `RESET_CYC`, with all drives low.
- R3: The line is watched from cycle `FILT_CYC`. A device chirp K is accepted only after `line_st` has read K on `FILT_CYC` consecutive watched cycles. A shorter run of K has no effect on the drives.
- R4: After acceptance, the first cycle t at which `line_st` is not K ends the device chirp. The host's first chirp K starts at cycle t+1, which is far inside the 100 µs reply bound.
- R5: Each host chirp is driven for exactly `CHIRP_CYC` cycles. Chirps alternate K, J, K, J, …, starting with K.
- R6: No host chirp is driven at or after cycle `CUT_CYC`. A chirp is started only if it ends by then. Every cycle of reset that carries no chirp drives SE0.
- R7: `hs_mode` rises in the first SE0 cycle after the last host chirp. It stays high until the next start command.
- R8: If the device chirp is not accepted, or does not end early enough for one full host chirp to fit before `CUT_CYC`, no chirp is driven and `hs_mode` stays low.
- R9: A start command sampled during a handshake restarts from cycle 0 with `drv_se0` high and `hs_mode` cleared on the next cycle.
- R10: At most one of `drv_se0`, `drv_k` and `drv_j` is high in any cycle.
- R11: Line code 2'b10 is chirp K, 2'b01 is chirp J and 2'b00 is SE0. Code 2'b11 is not K and breaks a K run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a port reset handshake |
| line_st | input | 2 | Decoded receive line state (00 SE0, 01 J, 10 K, 11 invalid) |
| drv_se0 | output | 1 | Drive SE0 on the port |
| drv_k | output | 1 | Drive chirp K on the port |
| drv_j | output | 1 | Drive chirp J on the port |
| rst_done | output | 1 | One-cycle strobe at the end of the reset interval |
| hs_mode | output | 1 | Port negotiated high speed |

## Verification
The bench builds the block with `CLK_KHZ=2000` and `RESET_US=2000`, leaving the other windows at their defaults. This gives a 4000-cycle reset, a 5-cycle qualification, 100-cycle chirps and a cutoff at cycle 3400. With these values a full handshake fits in a few thousand cycles, so each run covers the whole reset interval. The smaller values also put the decisive boundaries within reach: a device K one cycle short of qualification versus exactly long enough, and a device K ending exactly when one host chirp still fits versus one cycle too late. The same values cover an invalid code breaking a K run and a restart in the middle of the chirp train.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET_SE0,
        ST_WAIT_DEV_K,
        ST_WAIT_K_END,
        ST_HOST_CHIRP,
        ST_FINAL_SE0,
        ST_DONE
    } hsk_state_e;

    localparam logic [1:0] LS_SE0 = 2'b00;
    localparam logic [1:0] LS_J   = 2'b01;
    localparam logic [1:0] LS_K   = 2'b10;

endpackage

// File: rtl/hsk_k_qualifier.sv
module hsk_k_qualifier #(
    parameter int N_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic is_k,
    output logic qualified
);
    localparam int CW = $clog2(N_CYC + 1);
    localparam logic [CW-1:0] TOP = CW'(N_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || !is_k) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qualified = en && is_k && (cnt_q == TOP);

    generate
        if (N_CYC > 1) begin : g_chk
            // R3: acceptance needs the K run to have been watched before this cycle
            a_r3_k_run_before_accept: assert property (@(posedge clk) disable iff (!rst_n)
                qualified |-> $past(en && is_k));
        end
    endgenerate

endmodule

// File: rtl/hsk_chirp_timer.sv
module hsk_chirp_timer #(
    parameter int W_CYC = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last,
    output logic pol_j
);
    localparam int CW = $clog2(W_CYC + 1);
    localparam logic [CW-1:0] TOP = CW'(W_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pol;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = '0;
            r_d.pol = 1'b0;
        end else if (run) begin
            if (r_q.cnt == TOP) begin
                r_d.cnt = '0;
                r_d.pol = ~r_q.pol;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign last  = run && (r_q.cnt == TOP);
    assign pol_j = r_q.pol;

    // R5: a train always opens with K
    a_r5_first_is_k: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pol_j);
    // R5: polarity holds through the body of a chirp
    a_r5_pol_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last && !load) |=> $stable(pol_j));

endmodule

// File: rtl/hs_rst_handshake.sv
module hs_rst_handshake
    import hsk_pkg::*;
#(
    parameter int CLK_KHZ   = 48000,
    parameter int RESET_US  = 10000,
    parameter int FILT_NS   = 2500,
    parameter int CHIRP_US  = 50,
    parameter int CUTOFF_US = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] line_st,
    output logic       drv_se0,
    output logic       drv_k,
    output logic       drv_j,
    output logic       rst_done,
    output logic       hs_mode
);
    localparam int RESET_CYC = RESET_US * CLK_KHZ / 1000;
    localparam int FILT_CYC  = (FILT_NS * CLK_KHZ + 999999) / 1000000;
    localparam int LEAD_CYC  = FILT_CYC;
    localparam int CHIRP_CYC = CHIRP_US * CLK_KHZ / 1000;
    localparam int CUT_CYC   = RESET_CYC - CUTOFF_US * CLK_KHZ / 1000;
    localparam int TW        = $clog2(RESET_CYC + 1);

    localparam logic [TW-1:0] LEAD_END   = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0] CUT_T      = TW'(CUT_CYC);
    localparam logic [TW-1:0] LAST_START = TW'(CUT_CYC - CHIRP_CYC);
    localparam logic [TW-1:0] RESET_END  = TW'(RESET_CYC - 1);

    typedef struct packed {
        hsk_state_e    st;
        logic [TW-1:0] t;
        logic          hs;
    } ctl_t;

    ctl_t r_d, r_q;

    logic          line_is_k;
    logic          k_qual;
    logic          chirp_last;
    logic          chirp_pol_j;
    logic          chirp_load;
    logic [TW-1:0] t_nx;

    assign line_is_k = (line_st == LS_K);
    assign t_nx      = r_q.t + 1'b1;

    hsk_k_qualifier #(.N_CYC(FILT_CYC)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (r_q.st == ST_WAIT_DEV_K),
        .is_k      (line_is_k),
        .qualified (k_qual)
    );

    hsk_chirp_timer #(.W_CYC(CHIRP_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (chirp_load),
        .run   (r_q.st == ST_HOST_CHIRP),
        .last  (chirp_last),
        .pol_j (chirp_pol_j)
    );

    always_comb begin
        r_d        = r_q;
        chirp_load = 1'b0;
        case (r_q.st)
            ST_IDLE: ;
            ST_RESET_SE0: begin
                r_d.t = t_nx;
                if (r_q.t == LEAD_END) r_d.st = ST_WAIT_DEV_K;
            end
            ST_WAIT_DEV_K: begin
                r_d.t = t_nx;
                if (t_nx >= CUT_T)   r_d.st = ST_FINAL_SE0;
                else if (k_qual)     r_d.st = ST_WAIT_K_END;
            end
            ST_WAIT_K_END: begin
                r_d.t = t_nx;
                if (t_nx >= CUT_T) begin
                    r_d.st = ST_FINAL_SE0;
                end else if (!line_is_k) begin
                    if (t_nx <= LAST_START) begin
                        r_d.st     = ST_HOST_CHIRP;
                        chirp_load = 1'b1;
                    end else begin
                        r_d.st = ST_FINAL_SE0;
                    end
                end
            end
            ST_HOST_CHIRP: begin
                r_d.t = t_nx;
                if (chirp_last && (t_nx > LAST_START)) begin
                    r_d.st = ST_FINAL_SE0;
                    r_d.hs = 1'b1;
                end
            end
            ST_FINAL_SE0: begin
                r_d.t = t_nx;
                if (r_q.t == RESET_END) r_d.st = ST_DONE;
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        if (start) begin
            r_d.st = ST_RESET_SE0;
            r_d.t  = '0;
            r_d.hs = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, t: '0, hs: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        drv_se0 = (r_q.st == ST_RESET_SE0) || (r_q.st == ST_WAIT_DEV_K) ||
                  (r_q.st == ST_WAIT_K_END) || (r_q.st == ST_FINAL_SE0);
        drv_k   = (r_q.st == ST_HOST_CHIRP) && !chirp_pol_j;
        drv_j   = (r_q.st == ST_HOST_CHIRP) &&  chirp_pol_j;
    end

    assign rst_done = (r_q.st == ST_DONE);
    assign hs_mode  = r_q.hs;

    a_r10_drive_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_se0, drv_k, drv_j}));
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> !rst_done);
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (drv_se0 && !hs_mode && !rst_done));
    a_r6_no_late_chirp: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_k || drv_j) |-> (r_q.t < CUT_T));
    a_r7_hs_after_train: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> $past(r_q.st == ST_HOST_CHIRP));
    a_r4_prompt_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_K_END && !line_is_k && !start && t_nx <= LAST_START) |=> drv_k);

endmodule

// File: tb/hs_rst_handshake_bench.sv
module hs_rst_handshake_bench;
    // Derived by hand from the requirements for CLK_KHZ=2000, RESET_US=2000
    localparam int RST_C  = 4000;
    localparam int FILT_C = 5;
    localparam int LEAD_C = 5;
    localparam int CH_C   = 100;
    localparam int CUT_C  = 3400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] line_st = 2'b00;
    logic       drv_se0, drv_k, drv_j, rst_done, hs_mode;

    hs_rst_handshake #(.CLK_KHZ(2000), .RESET_US(2000)) u_hs_rst_handshake (
        .clk(clk), .rst_n(rst_n), .start(start), .line_st(line_st),
        .drv_se0(drv_se0), .drv_k(drv_k), .drv_j(drv_j),
        .rst_done(rst_done), .hs_mode(hs_mode)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int actv, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actv, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // ---------------- behavioural reference model ----------------
    int m_act = 0, m_t = 0, m_streak = 0, m_qual = 0, m_qual_t = 0, m_dead = 0, m_cs = -1;
    bit e_se0 = 0, e_k = 0, e_j = 0, e_done = 0, e_hs = 0;

    function automatic int n_chirps(input int cs);
        return (CUT_C - cs) / CH_C;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_cs = -1; e_hs = 0;
        end else if (start) begin
            m_act = 1; m_t = 0; m_streak = 0; m_qual = 0; m_dead = 0; m_cs = -1; e_hs = 0;
        end else if (m_act != 0) begin
            if (m_t >= RST_C) begin
                m_act = 0;
            end else begin
                if (m_cs < 0 && m_dead == 0 && m_t >= LEAD_C) begin
                    if (m_qual == 0) begin
                        m_streak = (line_st == 2'b10) ? m_streak + 1 : 0;
                        if (m_t + 1 >= CUT_C) m_dead = 1;
                        else if (m_streak >= FILT_C) begin m_qual = 1; m_qual_t = m_t; end
                    end else if (m_t > m_qual_t) begin
                        if (m_t + 1 >= CUT_C) m_dead = 1;
                        else if (line_st != 2'b10) begin
                            if (m_t + 1 + CH_C <= CUT_C) m_cs = m_t + 1;
                            else m_dead = 1;
                        end
                    end
                end
                m_t++;
            end
        end
        e_se0 = 0; e_k = 0; e_j = 0; e_done = 0;
        if (m_act != 0) begin
            if (m_t == RST_C) e_done = 1;
            else if (m_cs >= 0 && m_t >= m_cs && m_t < m_cs + n_chirps(m_cs) * CH_C) begin
                if (((m_t - m_cs) / CH_C) % 2 == 0) e_k = 1; else e_j = 1;
            end else e_se0 = 1;
            if (m_cs >= 0 && m_t >= m_cs + n_chirps(m_cs) * CH_C) e_hs = 1;
        end
    end

    // ---------------- monitor and per-cycle comparison ----------------
    int mon_t = 0, done_cnt = 0, chirp_cnt = 0, first_k = -1;
    bit mon_start = 0;

    always @(posedge clk) begin
        mon_start = start;
        if (start) mon_t = 0; else mon_t++;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_start) begin done_cnt = 0; chirp_cnt = 0; first_k = -1; end
            mon_start = 0;
            if (drv_k || drv_j) chirp_cnt++;
            if (drv_k && first_k < 0) first_k = mon_t;
            if (rst_done) done_cnt++;
            if (rst_done != e_done)
                chk(0, "R2", "done strobe", int'(rst_done), int'(e_done));
            else if (hs_mode != e_hs)
                chk(0, "R7", "hs flag", int'(hs_mode), int'(e_hs));
            else if ({drv_se0, drv_k, drv_j} != {e_se0, e_k, e_j})
                chk(0, (e_k || e_j) ? "R5" : (m_cs >= 0 ? "R6" : "R3"), "drive vector",
                    int'({drv_se0, drv_k, drv_j}), int'({e_se0, e_k, e_j}));
            else
                chk(1, "R10", "cycle match", 0, 0);
        end
    end

    // ---------------- stimulus ----------------
    bit restarted = 0;

    task automatic run(input int k_on, input int k_off, input int bad_at, input int cut_at,
                       input bit issue_start, input int exp_ch, input int exp_first,
                       input bit exp_hs, input string ktag);
        if (issue_start) begin
            @(negedge clk);
            start = 1'b1;
            line_st = 2'b00;
        end
        for (int t = 0; t <= RST_C + 1; t++) begin
            @(negedge clk);
            start = 1'b0;
            if (t == 0)
                chk(drv_se0 && !hs_mode, restarted ? "R9" : "R2", "SE0 at cycle 0, flag clear",
                    int'({drv_se0, hs_mode}), 2);
            line_st = (t >= k_on && t < k_off) ? ((t == bad_at) ? 2'b11 : 2'b10) : 2'b00;
            if (t == cut_at) begin
                start = 1'b1;
                restarted = 1;
                return;
            end
        end
        restarted = 0;
        line_st = 2'b00;
        @(posedge clk);
        #1;
        chk(done_cnt == 1, "R2", "done strobes", done_cnt, 1);
        chk(chirp_cnt == exp_ch, exp_ch == 0 ? "R8" : "R6", "host chirp cycles", chirp_cnt, exp_ch);
        chk(first_k == exp_first, ktag, "first host K cycle", first_k, exp_first);
        chk(hs_mode == exp_hs, exp_hs ? "R7" : "R8", "final hs flag", int'(hs_mode), int'(exp_hs));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({drv_se0, drv_k, drv_j, rst_done, hs_mode} == 5'b0, "R1", "outputs after reset",
            int'({drv_se0, drv_k, drv_j, rst_done, hs_mode}), 0);
        // R4 R5: device K 50..249, reply at 251, 31 chirps
        run(50, 250, -1, -1, 1, 3100, 251, 1, "R4");
        // R8: silent device
        run(-1, -1, -1, -1, 1, 0, -1, 0, "R8");
        // R3: K for FILT_C-1 cycles is ignored
        run(10, 14, -1, -1, 1, 0, -1, 0, "R3");
        // R3: K for exactly FILT_C cycles is accepted, reply at 16, 33 chirps
        run(10, 15, -1, -1, 1, 3300, 16, 1, "R3");
        // R11: invalid code at 12 breaks the run, K ends at 300, 30 chirps
        run(10, 300, 12, -1, 1, 3000, 301, 1, "R11");
        // R8: device K never ends before cutoff
        run(20, RST_C + 10, -1, -1, 1, 0, -1, 0, "R8");
        // R6: K ends so that exactly one chirp fits
        run(3000, 3299, -1, -1, 1, 100, 3300, 1, "R6");
        // R6: one cycle later, nothing fits
        run(3000, 3300, -1, -1, 1, 0, -1, 0, "R6");
        // R9: restart in the middle of the chirp train, then a full run
        run(50, 250, -1, 1000, 1, 0, -1, 0, "R9");
        run(50, 250, -1, -1, 0, 3100, 251, 1, "R9");
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

endmodule